// File: doc/BRIEF.md
# Four-Channel Prescaled Pulse Width Modulator

This block drives four independent pulse-width-modulated outputs, each set up through a small single-cycle register bus. A shared control word holds one run bit per channel and one 2-bit clock-scale code per channel. Every channel also has its own setup word, which holds an 8-bit period length and an 8-bit high-time length. Both lengths are counted in step ticks.

Each channel makes its step tick from the input clock through two cascaded sub-dividers, one dividing by 8 and one by 64. The scale code picks a step of 1, 8, 64 or 512 clocks. A step counter runs from 0 to period-1. The output is high while that count is below the high-time value. New period or high-time values are held in the register and taken into the running channel only when its current period ends, so a running waveform never shows a cut pulse.

Top module: `pwmq_top`

## Requirements
- R1: The four channels run independently. Channel c drives bit c of `pwmOut`, and the settings of one channel never change the waveform of another.
- R2: The control word is at byte offset 0x00. Bit c (c = 0..3) is the run bit of channel c. Bits [2c+5:2c+4] hold the scale code of channel c. A read returns the written value of bits [11:0]; all other bits read as zero.
- R3: Channel c's setup word is at byte offset 0x04 + 4c. The period length is in bits [7:0] and the high-time length is in bits [23:16]; all other bits read as zero. A read of any other offset, including a misaligned one, returns zero.
- R4: Scale codes 0, 1, 2 and 3 make each step last 1, 8, 64 and 512 input clocks.
- R5: Let k be the clock edge that sets a channel's run bit. From the cycle after edge k, the output is high in cycle i (i = 0 in that cycle) exactly when floor(i/step) mod period < high-time.
- R6: A high-time of 0 keeps the output low. A high-time equal to or above the period keeps the output high while the channel runs.
- R7: A period length of 0 holds the output low. The step counter stays at zero.
- R8: A setup write to a running channel takes effect only at the start of its next period. The period in progress finishes with the old values.
- R9: Clearing a run bit drives that output low from the next cycle. It also clears the channel's step counter and both sub-dividers, so setting the bit again starts a fresh period.
- R10: After reset, all outputs are low and all registers read zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busSel | input | 1 | Bus access in this cycle |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | 8 | Byte offset |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, valid in the same cycle as a read |
| pwmOut | output | 4 | PWM outputs, one bit per channel |

## Verification
The hardest case to reach from the ports is a channel whose sub-dividers and step counter hold nonzero values at the moment its run bit is cleared. If that state leaked into the restart, the waveform would only be shifted by a few clocks. The bench runs a channel at divide-by-8 for a number of clocks chosen so that both counters sit mid-count, then clears and sets the run bit. It then compares every cycle of the restarted waveform against a pattern counted from zero. A second hard case is a setup write that lands mid-period. The bench writes new values a few steps into a period and checks that the old period completes before the new shape starts.

// File: rtl/pwmq_pkg.sv
package pwmq_pkg;
  localparam int NUM_CH     = 4;
  localparam int TB_W       = 8;
  localparam int DUTY_W     = 8;
  localparam int SEL_W      = 2;
  localparam int DIV_A_W    = 3;   // divide-by-8 stage
  localparam int DIV_B_W    = 6;   // divide-by-64 stage
  localparam int ADDR_W     = 8;
  localparam int DATA_W     = 32;
  localparam int CTRL_OFS   = 0;
  localparam int CFG_BASE   = 4;
  localparam int CFG_STRIDE = 4;
  localparam int SEL_LSB    = 4;
  localparam int DUTY_LSB   = 16;

  typedef struct packed {
    logic              enable;
    logic [SEL_W-1:0]  divSel;
    logic [TB_W-1:0]   timebase;
    logic [DUTY_W-1:0] duty;
  } chanCtl_t;
endpackage

// File: rtl/pwmq_regs.sv
module pwmq_regs
  import pwmq_pkg::*;
(
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      busSel,
  input  logic                      busWrite,
  input  logic [ADDR_W-1:0]         busAddr,
  input  logic [DATA_W-1:0]         busWdata,
  output logic [DATA_W-1:0]         busRdata,
  output chanCtl_t [NUM_CH-1:0]     chanCtl
);
  logic [NUM_CH-1:0]                enReg;
  logic [NUM_CH-1:0][SEL_W-1:0]     selReg;
  logic [NUM_CH-1:0][TB_W-1:0]      tbReg;
  logic [NUM_CH-1:0][DUTY_W-1:0]    dutyReg;
  logic                             ctrlHit;
  logic [NUM_CH-1:0]                cfgHit;

  assign ctrlHit = busSel && (busAddr == ADDR_W'(CTRL_OFS));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enReg  <= '0;
      selReg <= '0;
    end else if (ctrlHit && busWrite) begin
      enReg <= busWdata[NUM_CH-1:0];
      for (int c = 0; c < NUM_CH; c++)
        selReg[c] <= busWdata[SEL_LSB + SEL_W*c +: SEL_W];
    end
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_cfg
    assign cfgHit[c] = busSel && (busAddr == ADDR_W'(CFG_BASE + c*CFG_STRIDE));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        tbReg[c]   <= '0;
        dutyReg[c] <= '0;
      end else if (cfgHit[c] && busWrite) begin
        tbReg[c]   <= busWdata[TB_W-1:0];
        dutyReg[c] <= busWdata[DUTY_LSB +: DUTY_W];
      end
    end

    assign chanCtl[c].enable   = enReg[c];
    assign chanCtl[c].divSel   = selReg[c];
    assign chanCtl[c].timebase = tbReg[c];
    assign chanCtl[c].duty     = dutyReg[c];
  end

  always_comb begin
    busRdata = '0;
    if (!busWrite) begin
      if (ctrlHit) begin
        busRdata[NUM_CH-1:0] = enReg;
        for (int c = 0; c < NUM_CH; c++)
          busRdata[SEL_LSB + SEL_W*c +: SEL_W] = selReg[c];
      end
      for (int c = 0; c < NUM_CH; c++) begin
        if (cfgHit[c]) begin
          busRdata[TB_W-1:0]          = tbReg[c];
          busRdata[DUTY_LSB +: DUTY_W] = dutyReg[c];
        end
      end
    end
  end

  // R2
  ctrl_write_lands_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlHit && busWrite) |=> (enReg == $past(busWdata[NUM_CH-1:0])));
endmodule

// File: rtl/pwmq_channel.sv
module pwmq_channel
  import pwmq_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  chanCtl_t ctl,
  output logic     pwmOut
);
  localparam logic [DIV_A_W-1:0] A_LAST = '1;
  localparam logic [DIV_B_W-1:0] B_LAST = '1;

  logic [DIV_A_W-1:0] cntA;
  logic [DIV_B_W-1:0] cntB;
  logic [TB_W-1:0]    stepCnt;
  logic [TB_W-1:0]    actTb;
  logic [DUTY_W-1:0]  actDuty;
  logic               aWrap, bWrap, stepTick, periodEnd;

  assign aWrap = (cntA == A_LAST);
  assign bWrap = (cntB == B_LAST);

  // cascaded sub-dividers: code bit0 routes through the /8 stage,
  // code bit1 through the /64 stage
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntA <= '0;
      cntB <= '0;
    end else if (!ctl.enable) begin
      cntA <= '0;
      cntB <= '0;
    end else begin
      cntA <= ctl.divSel[0] ? cntA + 1'b1 : '0;
      if (ctl.divSel[1]) begin
        if (!ctl.divSel[0] || aWrap) cntB <= cntB + 1'b1;
      end else begin
        cntB <= '0;
      end
    end
  end

  always_comb begin
    unique case (ctl.divSel)
      2'd0:    stepTick = 1'b1;
      2'd1:    stepTick = aWrap;
      2'd2:    stepTick = bWrap;
      default: stepTick = aWrap && bWrap;
    endcase
  end

  assign periodEnd = (actTb == '0) || (stepCnt == actTb - TB_W'(1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stepCnt <= '0;
      actTb   <= '0;
      actDuty <= '0;
    end else if (!ctl.enable) begin
      stepCnt <= '0;
      actTb   <= ctl.timebase;
      actDuty <= ctl.duty;
    end else if (stepTick) begin
      if (periodEnd) begin
        stepCnt <= '0;
        actTb   <= ctl.timebase;
        actDuty <= ctl.duty;
      end else begin
        stepCnt <= stepCnt + 1'b1;
      end
    end
  end

  assign pwmOut = ctl.enable && (actTb != '0) && (stepCnt < actDuty);

  // R7
  step_in_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.enable && actTb != '0) |-> (stepCnt < actTb));

  // R9
  disable_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.enable |=> (stepCnt == '0 && cntA == '0 && cntB == '0));

  // R8
  mid_period_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.enable && $past(ctl.enable) && stepCnt != '0) |->
      ($stable(actTb) && $stable(actDuty)));

  // R4
  tick_spacing_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.enable && ctl.divSel != 2'd0 && stepTick) |=>
      (!stepTick || ctl.divSel != $past(ctl.divSel)));
endmodule

// File: rtl/pwmq_top.sv
module pwmq_top
  import pwmq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [7:0]        busAddr,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  output logic [3:0]        pwmOut
);
  chanCtl_t [NUM_CH-1:0] chanCtl;

  pwmq_regs u_regs (
    .clk      (clk),
    .rstN     (rstN),
    .busSel   (busSel),
    .busWrite (busWrite),
    .busAddr  (busAddr),
    .busWdata (busWdata),
    .busRdata (busRdata),
    .chanCtl  (chanCtl)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    pwmq_channel u_ch (
      .clk    (clk),
      .rstN   (rstN),
      .ctl    (chanCtl[c]),
      .pwmOut (pwmOut[c])
    );
  end
endmodule

// File: tb/pwmq_top_tb.sv
module pwmq_top_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busSel = 1'b0;
  logic        busWrite = 1'b0;
  logic [7:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [3:0]  pwmOut;

  int nChecks = 0;
  int nFails  = 0;

  always #4 clk = ~clk;

  pwmq_top u_dut (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata), .pwmOut(pwmOut)
  );

  // vector: {channel, period, high-time, scale code}
  localparam int NVEC = 9;
  localparam logic [31:0] VEC [NVEC] = '{
    {8'd0, 8'd10,  8'd3,   8'd0},
    {8'd1, 8'd16,  8'd16,  8'd0},
    {8'd2, 8'd8,   8'd0,   8'd1},
    {8'd3, 8'd5,   8'd2,   8'd1},
    {8'd0, 8'd4,   8'd1,   8'd2},
    {8'd1, 8'd3,   8'd2,   8'd3},
    {8'd2, 8'd255, 8'd128, 8'd0},
    {8'd3, 8'd0,   8'd5,   8'd0},
    {8'd0, 8'd6,   8'd9,   8'd0}
  };

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    busSel = 1'b1; busWrite = 1'b1; busAddr = a; busWdata = d;
    @(posedge clk); @(negedge clk);
    busSel = 1'b0; busWrite = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    busSel = 1'b1; busWrite = 1'b0; busAddr = a;
    #1 d = busRdata;
    @(posedge clk); @(negedge clk);
    busSel = 1'b0;
  endtask

  function automatic logic expOut(int i, int tb, int duty, int code);
    int step = 1 << (3 * code);
    if (tb == 0) return 1'b0;
    return ((i / step) % tb) < duty;
  endfunction

  function automatic logic [31:0] ctrlWord(int ch, int code);
    return (32'd1 << ch) | (32'(code) << (4 + 2*ch));
  endfunction

  task automatic runVec(int ch, int tb, int duty, int code, string req);
    int step = 1 << (3 * code);
    int win = ((tb > 10) ? tb : 10) * step * 2;
    int mism = 0;
    wr(8'h00, 32'h0);
    wr(8'(4 + 4*ch), {8'h00, 8'(duty), 8'h00, 8'(tb)});
    wr(8'h00, ctrlWord(ch, code));
    for (int i = 0; i < win; i++) begin
      if (pwmOut !== (4'(expOut(i, tb, duty, code)) << ch)) mism++;
      @(negedge clk);
    end
    chk(req, mism, 0);
  endtask

  logic [31:0] rv;

  initial begin
    #(8 * 200000);
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks + 1, nFails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R10 outputs in reset", 32'(pwmOut), 0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R10 outputs after reset", 32'(pwmOut), 0);
    rd(8'h00, rv); chk("R10 ctrl reset", rv, 0);
    for (int c = 0; c < 4; c++) begin
      rd(8'(4 + 4*c), rv); chk("R10 cfg reset", rv, 0);
    end

    // register layout and readback
    wr(8'h08, 32'hFFFF_FFFF);
    rd(8'h08, rv); chk("R3 cfg readback mask", rv, 32'h00FF_00FF);
    wr(8'h10, 32'h1234_5678);
    rd(8'h10, rv); chk("R3 cfg3 fields", rv, 32'h0034_0078);
    wr(8'h00, 32'hFFFF_FFF0);
    rd(8'h00, rv); chk("R2 ctrl readback mask", rv, 32'h0000_0FF0);
    wr(8'h00, 32'h0000_0000);
    rd(8'h14, rv); chk("R3 unmapped 0x14", rv, 0);
    rd(8'h02, rv); chk("R3 misaligned 0x02", rv, 0);
    rd(8'h80, rv); chk("R3 unmapped 0x80", rv, 0);

    // table walk
    for (int v = 0; v < NVEC; v++) begin
      int ch   = int'(VEC[v][31:24]);
      int tb   = int'(VEC[v][23:16]);
      int duty = int'(VEC[v][15:8]);
      int code = int'(VEC[v][7:0]);
      string req;
      if (tb == 0) req = "R7 zero period";
      else if (duty == 0 || duty >= tb) req = "R6 constant level";
      else if (code != 0) req = "R4 scale code";
      else req = "R5 waveform";
      runVec(ch, tb, duty, code, req);
    end

    // R1: two channels at once
    begin
      int mism = 0;
      wr(8'h00, 32'h0);
      wr(8'h04, {8'h00, 8'd2, 8'h00, 8'd5});
      wr(8'h10, {8'h00, 8'd1, 8'h00, 8'd3});
      wr(8'h00, 32'h9 | (32'd1 << 10));
      for (int i = 0; i < 96; i++) begin
        logic [3:0] e;
        e = {expOut(i, 3, 1, 1), 2'b00, expOut(i, 5, 2, 0)};
        if (pwmOut !== e) mism++;
        @(negedge clk);
      end
      chk("R1 independent channels", mism, 0);
    end

    // R8: mid-period update
    begin
      int mism = 0;
      wr(8'h00, 32'h0);
      wr(8'h0C, {8'h00, 8'd3, 8'h00, 8'd10});
      wr(8'h00, ctrlWord(2, 0));
      for (int i = 0; i < 5; i++) begin
        if (pwmOut !== (4'(i < 3) << 2)) mism++;
        @(negedge clk);
      end
      wr(8'h0C, {8'h00, 8'd1, 8'h00, 8'd4});
      for (int i = 6; i < 30; i++) begin
        logic e;
        e = (i < 10) ? (i < 3) : (((i - 10) % 4) < 1);
        if (pwmOut !== (4'(e) << 2)) mism++;
        @(negedge clk);
      end
      chk("R8 update at period boundary", mism, 0);
    end

    // R9: disable mid-count, then restart
    begin
      int mism = 0;
      wr(8'h00, 32'h0);
      wr(8'h08, {8'h00, 8'd8, 8'h00, 8'd10});
      wr(8'h00, ctrlWord(1, 1));
      repeat (20) @(negedge clk);
      chk("R9 high before disable", 32'(pwmOut), 32'h2);
      wr(8'h00, 32'h0);
      chk("R9 low after disable", 32'(pwmOut), 0);
      wr(8'h00, ctrlWord(1, 1));
      for (int i = 0; i < 160; i++) begin
        if (pwmOut !== (4'(expOut(i, 10, 8, 1)) << 1)) mism++;
        @(negedge clk);
      end
      chk("R9 restart from fresh period", mism, 0);
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule